// File: doc/BRIEF.md
# Parity-Protected Register Group

This block is a bank of data flip-flops that share one clock, one synchronous active-low reset and one load enable. It is split into equal groups of bits. Each group carries one extra flip-flop that holds the even parity of that group's data. The parity flop is written on the same edge, under the same enable, as the data flops it covers. The goal is to catch transient upsets in stored state.

Every cycle, each group recomputes the parity of its live stored bits and compares it with its parity flop. The block ORs the per-group mismatches and registers the result once to form the error output. A mismatch means either a data flop or the parity flop itself has been disturbed. The error stays high for as long as the disturbed state is held.

A test-only inject port XORs a mask into the next stored data and parity state. This lets detection be checked without touching the functional load path. The block does not correct, recover from or report errors beyond the flag.

Top module: `parity_guarded_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, `dout` becomes all zeros and `par_err` becomes 0 at that edge, whatever the other inputs are.
- R2: At a rising edge with `load_en` high and `inj_en` low, `dout` takes `din`. With both low, `dout` keeps its value.
- R3: After any load without injection, the stored parity matches the stored data, and `par_err` is 0 one cycle after the load edge, for any data pattern.
- R4: Bit i of `inj_data_mask`, applied with `inj_en` high, flips bit i of the stored data. A single such flip in any bit makes `par_err` go high one cycle after the flipped value is stored.
- R5: Bit g of `inj_par_mask`, applied with `inj_en` high, flips the parity flop of group g, which covers `dout[g*GROUP_W +: GROUP_W]`. Flipping a parity flop alone makes `par_err` go high one cycle later.
- R6: `par_err` stays high on every cycle while the disturbed state is held, including while `load_en` is low. It falls one cycle after a clean load restores consistency.
- R7: An even number of flips within one group goes undetected and `par_err` stays 0. This includes two data bits of the group, or one data bit together with that group's parity flop.
- R8: Groups are checked independently, so one flip in each of two different groups is detected.
- R9: When `load_en` and `inj_en` are high on the same edge, the stored data becomes `din ^ inj_data_mask` and the resulting mismatch is flagged one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flops |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load enable shared by data and parity flops |
| din | input | DATA_W | Data word to store |
| inj_en | input | 1 | Test-only: apply the injection masks at this edge |
| inj_data_mask | input | DATA_W | Test-only: stored data bits to flip |
| inj_par_mask | input | DATA_W/GROUP_W | Test-only: group parity flops to flip |
| dout | output | DATA_W | Stored data word |
| par_err | output | 1 | Registered parity mismatch flag |

## Verification
The bench builds the block with DATA_W = 16 and GROUP_W = 4, which gives four parity groups. Having several groups lets the bench tell apart two flips inside one group, which cancel, from one flip in each of two groups, which must both be seen. Every one of the sixteen data bits and every one of the four parity flops is flipped in turn. This shows that no position escapes detection and that each group's parity covers exactly its own slice.

// File: rtl/pgr_pkg.sv
// Package: shared helpers for the parity-protected register group.
// Assumes the data width is a whole multiple of the group width.
package pgr_pkg;
    // Number of parity groups for a given data and group width.
    function automatic int grp_count(input int data_w, input int group_w);
        return data_w / group_w;
    endfunction
endpackage

// File: rtl/pgr_slice.sv
// pgr_slice: one parity group. It holds GW data flops and one parity flop,
// all under the same clock, reset and load enable. It reports a live
// mismatch between the stored parity and the parity of the stored data.
// Assumes the injection masks are zero during functional use.
module pgr_slice #(
    parameter int GW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inj_en,
    input  logic [GW-1:0] d,
    input  logic [GW-1:0] inj_mask,
    input  logic          inj_par,
    output logic [GW-1:0] q,
    output logic          par_q,
    output logic          mismatch
);
    logic [GW-1:0] q_nxt;
    logic          par_nxt;

    // Next state: load or hold, then optional test-only bit flips.
    always_comb begin
        q_nxt   = load ? d : q;
        par_nxt = load ? ^d : par_q;
        if (inj_en) begin
            q_nxt   = q_nxt ^ inj_mask;
            par_nxt = par_nxt ^ inj_par;
        end
    end

    // Storage: data and parity flops, reset to a consistent all-zero state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            par_q <= 1'b0;
        end else begin
            q     <= q_nxt;
            par_q <= par_nxt;
        end
    end

    // Continuous check of the live contents against the parity flop.
    always_comb mismatch = (^q) ^ par_q;
endmodule

// File: rtl/pgr_err_reg.sv
// pgr_err_reg: ORs the per-group mismatches and registers the result once.
// Assumes the mismatch inputs come straight from stored state.
module pgr_err_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grp_mis,
    output logic         err
);
    // Error flag register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= |grp_mis;
    end
endmodule

// File: rtl/parity_guarded_reg.sv
// parity_guarded_reg: a register bank split into equal parity groups.
// Each group has its own parity flop, and the combined mismatch is
// registered onto par_err. Assumes DATA_W is a multiple of GROUP_W.
module parity_guarded_reg #(
    parameter int DATA_W  = 16,
    parameter int GROUP_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [DATA_W-1:0]             din,
    input  logic                          inj_en,
    input  logic [DATA_W-1:0]             inj_data_mask,
    input  logic [DATA_W/GROUP_W-1:0]     inj_par_mask,
    output logic [DATA_W-1:0]             dout,
    output logic                          par_err
);
    localparam int NUM_GRP = pgr_pkg::grp_count(DATA_W, GROUP_W);

    logic [NUM_GRP-1:0] par_bits;
    logic [NUM_GRP-1:0] grp_mis;

    // One slice per parity group.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        pgr_slice #(.GW(GROUP_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_en),
            .inj_en   (inj_en),
            .d        (din[g*GROUP_W +: GROUP_W]),
            .inj_mask (inj_data_mask[g*GROUP_W +: GROUP_W]),
            .inj_par  (inj_par_mask[g]),
            .q        (dout[g*GROUP_W +: GROUP_W]),
            .par_q    (par_bits[g]),
            .mismatch (grp_mis[g])
        );
    end

    pgr_err_reg #(.N(NUM_GRP)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_mis (grp_mis),
        .err     (par_err)
    );
endmodule

// File: rtl/pgr_checker.sv
// pgr_checker: properties for parity_guarded_reg, attached by bind.
// It recomputes group parity from dout and the stored parity bits.
module pgr_checker #(
    parameter int DATA_W  = 16,
    parameter int GROUP_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      load_en,
    input logic [DATA_W-1:0]         din,
    input logic                      inj_en,
    input logic [DATA_W-1:0]         inj_data_mask,
    input logic [DATA_W/GROUP_W-1:0] inj_par_mask,
    input logic [DATA_W-1:0]         dout,
    input logic [DATA_W/GROUP_W-1:0] par_bits,
    input logic                      par_err
);
    localparam int NG = DATA_W / GROUP_W;

    logic [NG-1:0] recheck;

    // Independent recomputation of each group's mismatch.
    always_comb begin
        for (int g = 0; g < NG; g++)
            recheck[g] = (^dout[g*GROUP_W +: GROUP_W]) ^ par_bits[g];
    end

    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (dout == '0) && !par_err);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && !inj_en |=> dout == $past(din));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en && !inj_en |=> $stable(dout));

    p_clean_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en && !inj_en |=> ##1 !par_err);

    p_err_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> par_err == $past(|recheck));

    p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en && ($countones({inj_data_mask, inj_par_mask}) == 1) |=> ##1 par_err);
endmodule

bind parity_guarded_reg pgr_checker #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_en       (load_en),
    .din           (din),
    .inj_en        (inj_en),
    .inj_data_mask (inj_data_mask),
    .inj_par_mask  (inj_par_mask),
    .dout          (dout),
    .par_bits      (par_bits),
    .par_err       (par_err)
);

// File: tb/parity_guarded_reg_test.sv
module parity_guarded_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int GW = 4;
    localparam int NG = DW / GW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_en;
    logic [DW-1:0] din;
    logic          inj_en;
    logic [DW-1:0] inj_data_mask;
    logic [NG-1:0] inj_par_mask;
    logic [DW-1:0] dout;
    logic          par_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    parity_guarded_reg #(.DATA_W(DW), .GROUP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .din(din),
        .inj_en(inj_en), .inj_data_mask(inj_data_mask),
        .inj_par_mask(inj_par_mask), .dout(dout), .par_err(par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [DW-1:0] v);
        load_en = 1'b1; din = v;
        step();
        load_en = 1'b0;
    endtask

    task automatic do_inject(input logic [DW-1:0] dm, input logic [NG-1:0] pm);
        inj_en = 1'b1; inj_data_mask = dm; inj_par_mask = pm;
        step();
        inj_en = 1'b0; inj_data_mask = '0; inj_par_mask = '0;
    endtask

    // Clean start: load a value and let the error flag settle.
    task automatic settle(input logic [DW-1:0] v);
        do_load(v);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; load_en = 1'b1; din = 16'hFFFF;
        step(); step();
        check("R1 dout", dout, '0);
        check("R1 err", par_err, 0);
        load_en = 1'b0; rst_n = 1'b1;
        step();
        check("R1 err after release", par_err, 0);
        // Reset also clears a raised error.
        settle(16'hA5A5);
        do_inject(16'h0008, '0);
        step();
        check("R1 err raised", par_err, 1);
        rst_n = 1'b0;
        step();
        check("R1 err cleared by reset", par_err, 0);
        check("R1 dout cleared by reset", dout, '0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_load_hold();
        logic [DW-1:0] pats [4] = '{16'hFFFF, 16'hA5A5, 16'h0001, 16'h8000};
        foreach (pats[i]) begin
            do_load(pats[i]);
            check("R2 load", dout, pats[i]);
            din = ~pats[i];
            step();
            check("R2 hold", dout, pats[i]);
            check("R3 no false error", par_err, 0);
        end
    endtask

    task automatic t_single_data();
        for (int i = 0; i < DW; i++) begin
            settle(16'h3C96);
            do_inject(DW'(1) << i, '0);
            check("R4 flipped bit stored", dout, 16'h3C96 ^ (DW'(1) << i));
            check("R4 err one cycle later, still low", par_err, 0);
            step();
            check("R4 single data flip detected", par_err, 1);
            do_load(16'h3C96);
            step();
            check("R6 cleared after clean load", par_err, 0);
        end
    endtask

    task automatic t_parity_flop();
        for (int g = 0; g < NG; g++) begin
            settle(16'h1234);
            do_inject('0, NG'(1) << g);
            step();
            check("R5 parity flop flip detected", par_err, 1);
            check("R5 data untouched", dout, 16'h1234);
        end
        settle(16'h1234);
    endtask

    task automatic t_persist();
        settle(16'h00F0);
        do_inject(16'h0010, '0);
        for (int k = 0; k < 5; k++) begin
            step();
            check("R6 error persists", par_err, 1);
        end
        do_load(16'h00F0);
        check("R6 still high on load cycle", par_err, 1);
        step();
        check("R6 falls after clean load", par_err, 0);
    endtask

    task automatic t_even();
        settle(16'h5555);
        do_inject(16'h0030, '0);            // two bits of group 1
        check("R7 two flips stored", dout, 16'h5565);
        step(); step();
        check("R7 even flips in group undetected", par_err, 0);
        settle(16'h5555);
        do_inject(16'h0100, 4'b0100);       // data bit and parity of group 2
        step(); step();
        check("R7 data+parity flip undetected", par_err, 0);
        check("R7 data bit visibly flipped", dout, 16'h5455);
        settle(16'h5555);
    endtask

    task automatic t_cross();
        settle(16'h0F0F);
        do_inject(16'h0102, '0);            // group 0 and group 2
        step();
        check("R8 flips in two groups detected", par_err, 1);
        settle(16'h0F0F);
        check("R8 recovered", par_err, 0);
    endtask

    task automatic t_inject_on_load();
        settle(16'h0000);
        load_en = 1'b1; din = 16'hBEEF;
        inj_en = 1'b1; inj_data_mask = 16'h0400; inj_par_mask = '0;
        step();
        load_en = 1'b0; inj_en = 1'b0; inj_data_mask = '0;
        check("R9 stored din^mask", dout, 16'hBAEF);
        step();
        check("R9 mismatch flagged", par_err, 1);
        settle(16'hBEEF);
    endtask

    initial begin
        rst_n = 1'b0; load_en = 1'b0; din = '0;
        inj_en = 1'b0; inj_data_mask = '0; inj_par_mask = '0;
        @(negedge clk);
        t_reset();
        t_load_hold();
        t_single_data();
        t_parity_flop();
        t_persist();
        t_even();
        t_cross();
        t_inject_on_load();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule